// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Master

This block is a memory-mapped SPI master that runs one half-duplex transaction each time software writes a start command. A transaction has up to three phases, always in the same order. First a command is shifted out of a 32-bit opcode word. Next, transmit data is shifted out of a 32-byte data buffer. Last, receive data is sampled back into that same buffer. Software sets the length of each phase in bits. It then writes the start bit and polls a busy flag until the transaction is over.

The serial clock is SPI mode 0. SCK idles low, MOSI moves only at bit boundaries, which are the falling edges, and MISO is sampled on the rising edge. The SCK period is a programmable number of system clocks. Bits within a byte go out, and come back in, either most-significant-first or least-significant-first. Two chip-select outputs are driven directly from a polarity register. They stay put across transactions until software changes them, so several transactions can be framed under one select.

Registers sit on word-aligned byte offsets. The bus port carries the word address, which is the byte offset divided by 4. Reads are combinational from the word address.

Top module: `spi_hd_master`

## Requirements
- R1: After reset every register reads 0, both `spi_cs_n` outputs are high and `spi_sck` is low. The configuration word at 0x28 reads back the divider code in bits [27:16] and the bit-order flag in bit 3. Every other bit of that word reads 0, including bits 4 and 5.
- R2: Writing a 1 to bit 8 of the control word at 0x00 while idle starts a transaction. Bit 16 of that word reads 1 from the next cycle for exactly N*(code+2)+1 cycles, where N is the total bit count of the transaction.
- R3: Each bit lasts P = code+2 system clocks. In each bit, SCK is low for P - floor(P/2) clocks and then high for floor(P/2) clocks. SCK is low whenever no transaction runs. The code may be anything from 0 to 4095.
- R4: The bits on MOSI come in this order: all command bits, then all transmit bits, then receive bits. During the receive bits MOSI is 0. MOSI changes only at bit boundaries.
- R5: A command of C bits uses N = ceil(C/8) opcode bytes (opcode word at 0x04). The first byte sent is opcode byte N-1, the one in bits 8(N-1)+7..8(N-1). The bytes then go downward to byte 0. A final partial byte is cut off after C bits.
- R6: Transmit byte p is buffer byte p. Buffer byte p is in bits 8*(p mod 4)+7..8*(p mod 4) of buffer word p/4. Buffer word w sits at offset 0x08+4w.
- R7: Bit 3 of the configuration word sets the bit order within a byte: 0 sends bit 7 first, 1 sends bit 0 first. The same order applies to command bits, to transmit bits and to where received bits are placed.
- R8: Receive bit k is the MISO level at the rising SCK edge of overall bit (command+transmit+k). It is written into buffer byte k/8 at the position given by R7. Every other buffer bit keeps its value.
- R9: The count word at 0x2C reads back exactly as written. Command bits come from [31:24], with values above 32 treated as 32. Receive bits come from [23:12] and transmit bits from [11:0], with values above 256 treated as 256.
- R10: A start with all three counts zero holds busy for one cycle and produces no SCK edge.
- R11: While busy, a start write is ignored. Writes to the opcode, buffer, configuration and count words are also ignored. Reads return the current contents.
- R12: Bit n of the select word at 0x38 drives `spi_cs_n[n]` low. The bit may be written at any time, busy or not, and holds until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_waddr | input | 4 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr` |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | N_CS | Active-low chip selects |

## Verification
The bench goes after these corner cases:
- A command length that is not a whole number of bytes. A design that took bytes from the wrong end of the opcode would send the wrong first byte.
- An odd divider ratio. A design that split the period the wrong way would shift where SCK rises, and so where receive sampling happens.
- Receive lengths that stop inside a byte. A design that cleared or shifted whole bytes would corrupt the buffer bits that should be left alone.
- Oversized count fields and the largest divider. These catch truncation and overflow in the bit index and the phase counter.
- Restarts and buffer writes issued while busy. A design that accepted them would lengthen busy or change the data mid-stream.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
    localparam int BUF_WORDS = 8;
    localparam int BUF_BITS  = BUF_WORDS * 32;
    localparam int POS_W     = $clog2(BUF_BITS);
    localparam int CMD_MAX   = 32;
    localparam int CMD_W     = $clog2(CMD_MAX + 1);
    localparam int CNT_W     = $clog2(BUF_BITS + 1);
    localparam int IDX_W     = $clog2(CMD_MAX + 2 * BUF_BITS + 1);

    localparam logic [3:0] WA_CTRL = 4'd0;
    localparam logic [3:0] WA_OPC  = 4'd1;
    localparam logic [3:0] WA_BUF0 = 4'd2;
    localparam logic [3:0] WA_CFG  = 4'd10;
    localparam logic [3:0] WA_CNT  = 4'd11;
    localparam logic [3:0] WA_SEL  = 4'd14;

    typedef enum logic {ST_IDLE, ST_RUN} eng_state_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [CNT_W-1:0] tx;
        logic [CNT_W-1:0] rx;
    } bitcnt_t;

    function automatic bitcnt_t decode_counts(input logic [31:0] w);
        bitcnt_t c;
        c.cmd = (w[31:24] > 8'(CMD_MAX))   ? CMD_W'(CMD_MAX)  : w[24 +: CMD_W];
        c.rx  = (w[23:12] > 12'(BUF_BITS)) ? CNT_W'(BUF_BITS) : w[12 +: CNT_W];
        c.tx  = (w[11:0]  > 12'(BUF_BITS)) ? CNT_W'(BUF_BITS) : w[0 +: CNT_W];
        return c;
    endfunction

    function automatic logic [2:0] bit_in_byte(input logic [2:0] k, input logic lsb_first);
        return lsb_first ? k : 3'd7 - k;
    endfunction
endpackage

// File: rtl/spi_hd_clkdiv.sv
module spi_hd_clkdiv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] code,
    output logic             sck,
    output logic             bit_end,
    output logic             rise_next
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] period;
    logic [PH_W-1:0] low_len;

    assign period  = PH_W'(code) + PH_W'(2);
    assign low_len = period - (period >> 1);

    always_ff @(posedge clk) begin
        if (rst || !run)              ph <= '0;
        else if (ph == period - 1'b1) ph <= '0;
        else                          ph <= ph + 1'b1;
    end

    assign bit_end   = run && (ph == period - 1'b1);
    assign rise_next = run && (ph == low_len - 1'b1);
    assign sck       = run && (ph >= low_len);

    // R3: a sample strobe is followed by SCK high; a bit boundary by SCK low
    p_sck_rise_r3: assert property (@(posedge clk) disable iff (rst) rise_next |=> sck);
    p_sck_fall_r3: assert property (@(posedge clk) disable iff (rst) bit_end |=> !sck);
endmodule

// File: rtl/spi_hd_engine.sv
module spi_hd_engine
    import spi_hd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  bitcnt_t             cnts,
    input  logic                lsb_first,
    input  logic [31:0]         opcode,
    input  logic [BUF_BITS-1:0] buf_bits,
    input  logic                bit_end,
    input  logic                rise_next,
    output logic                busy,
    output logic                shifting,
    output logic                mosi,
    output logic                rx_we,
    output logic [POS_W-1:0]    rx_pos
);
    eng_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] n_cmd, n_out, n_all;
    logic [2:0]       n_opc_bytes;
    logic [1:0]       opc_byte;
    logic [4:0]       opc_pos;
    logic [POS_W-1:0] tx_k, rx_k, tx_pos;

    assign n_cmd = IDX_W'(cnts.cmd);
    assign n_out = n_cmd + IDX_W'(cnts.tx);
    assign n_all = n_out + IDX_W'(cnts.rx);

    assign busy     = (state == ST_RUN);
    assign shifting = busy && (idx < n_all);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    idx   <= '0;
                end
                ST_RUN: begin
                    if (idx == n_all) state <= ST_IDLE;
                    else if (bit_end) idx <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command bytes leave from the highest valid opcode byte downward
    assign n_opc_bytes = 3'((7'(cnts.cmd) + 7'd7) >> 3);
    assign opc_byte    = 2'(n_opc_bytes - 3'd1 - {1'b0, idx[4:3]});
    assign opc_pos     = {opc_byte, bit_in_byte(idx[2:0], lsb_first)};

    assign tx_k   = POS_W'(idx - n_cmd);
    assign rx_k   = POS_W'(idx - n_out);
    assign tx_pos = {tx_k[POS_W-1:3], bit_in_byte(tx_k[2:0], lsb_first)};
    assign rx_pos = {rx_k[POS_W-1:3], bit_in_byte(rx_k[2:0], lsb_first)};

    always_comb begin
        if (!shifting)          mosi = 1'b0;
        else if (idx < n_cmd)   mosi = opcode[opc_pos];
        else if (idx < n_out)   mosi = buf_bits[tx_pos];
        else                    mosi = 1'b0;
    end

    assign rx_we = shifting && rise_next && (idx >= n_out);

    // R11: the final busy cycle always returns to idle, whatever is written
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == n_all) |=> !busy);
    // R4: MOSI holds for the whole of a bit
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (shifting && !bit_end) |=> $stable(mosi));
endmodule

// File: rtl/spi_hd_master.sv
module spi_hd_master
    import spi_hd_pkg::*;
#(
    parameter int N_CS  = 2,
    parameter int DIV_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr_en,
    input  logic [3:0]      bus_waddr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            spi_sck,
    output logic            spi_mosi,
    input  logic            spi_miso,
    output logic [N_CS-1:0] spi_cs_n
);
    logic [31:0]         opc_q;
    logic [31:0]         cnt_q;
    logic [DIV_W-1:0]    div_q;
    logic                lsb_q;
    logic [N_CS-1:0]     sel_q;
    logic [BUF_BITS-1:0] buf_q;

    logic             busy, shifting, rx_we, bit_end, rise_next;
    logic             wr_ok, start;
    logic [POS_W-1:0] rx_pos;

    assign wr_ok = bus_wr_en && !busy;
    assign start = wr_ok && (bus_waddr == WA_CTRL) && bus_wdata[8];

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q <= '0;
            cnt_q <= '0;
            div_q <= '0;
            lsb_q <= 1'b0;
            sel_q <= '0;
            buf_q <= '0;
        end else begin
            if (wr_ok && bus_waddr == WA_OPC) opc_q <= bus_wdata;
            if (wr_ok && bus_waddr == WA_CNT) cnt_q <= bus_wdata;
            if (wr_ok && bus_waddr == WA_CFG) begin
                div_q <= bus_wdata[16 +: DIV_W];
                lsb_q <= bus_wdata[3];
            end
            for (int w = 0; w < BUF_WORDS; w++)
                if (wr_ok && bus_waddr == WA_BUF0 + 4'(w)) buf_q[32*w +: 32] <= bus_wdata;
            if (rx_we) buf_q[rx_pos] <= spi_miso;
            if (bus_wr_en && bus_waddr == WA_SEL) sel_q <= bus_wdata[N_CS-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_waddr)
            WA_CTRL: bus_rdata[16] = busy;
            WA_OPC:  bus_rdata = opc_q;
            WA_CNT:  bus_rdata = cnt_q;
            WA_CFG: begin
                bus_rdata[16 +: DIV_W] = div_q;
                bus_rdata[3]           = lsb_q;
            end
            WA_SEL:  bus_rdata[N_CS-1:0] = sel_q;
            default: begin
                for (int w = 0; w < BUF_WORDS; w++)
                    if (bus_waddr == WA_BUF0 + 4'(w)) bus_rdata = buf_q[32*w +: 32];
            end
        endcase
    end

    assign spi_cs_n = ~sel_q;

    spi_hd_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cnts      (decode_counts(cnt_q)),
        .lsb_first (lsb_q),
        .opcode    (opc_q),
        .buf_bits  (buf_q),
        .bit_end   (bit_end),
        .rise_next (rise_next),
        .busy      (busy),
        .shifting  (shifting),
        .mosi      (spi_mosi),
        .rx_we     (rx_we),
        .rx_pos    (rx_pos)
    );

    spi_hd_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk       (clk),
        .rst       (rst),
        .run       (shifting),
        .code      (div_q),
        .sck       (spi_sck),
        .bit_end   (bit_end),
        .rise_next (rise_next)
    );

    // R3: SCK idles low
    p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst) !busy |-> !spi_sck);
    // R12: selects move only on a write to the select word
    p_sel_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr_en && bus_waddr == WA_SEL) |=> $stable(spi_cs_n));
    // R11: during a transaction only received bits alter the buffer
    p_buf_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !rx_we) |=> $stable(buf_q));
endmodule

// File: tb/spi_hd_master_tb_top.sv
module spi_hd_master_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [1:0]  spi_cs_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_hd_master dut_i (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- SPI slave model ----------------
    logic [607:0] pat;
    int           edges = 0;
    bit           got_q[$];
    assign spi_miso = pat[edges % 608];
    always @(posedge spi_sck) begin
        got_q.push_back(spi_mosi);
        edges++;
    end

    // ---------------- reference model ----------------
    logic [31:0]  m_opc, m_cnt;
    logic [255:0] m_buf;
    logic [1:0]   m_sel;
    int           m_div, m_lsb;
    bit           m_busy;
    int           m_c, m_total, m_per, m_ncmd, m_ntx, m_nrx;
    bit           exp_q[$];

    function automatic int bpos(input int k, input int lsb);
        return 8 * (k / 8) + (lsb != 0 ? k % 8 : 7 - k % 8);
    endfunction

    function automatic void build_stream();
        int nb;
        m_ncmd = (m_cnt[31:24] > 32)  ? 32  : int'(m_cnt[31:24]);
        m_nrx  = (m_cnt[23:12] > 256) ? 256 : int'(m_cnt[23:12]);
        m_ntx  = (m_cnt[11:0]  > 256) ? 256 : int'(m_cnt[11:0]);
        nb = (m_ncmd + 7) / 8;
        exp_q.delete();
        for (int k = 0; k < m_ncmd; k++)
            exp_q.push_back(m_opc[8 * (nb - 1 - k / 8) + (m_lsb != 0 ? k % 8 : 7 - k % 8)]);
        for (int k = 0; k < m_ntx; k++) exp_q.push_back(m_buf[bpos(k, m_lsb)]);
        for (int k = 0; k < m_nrx; k++) exp_q.push_back(1'b0);
        m_total = m_ncmd + m_ntx + m_nrx;
    endfunction

    function automatic void apply_rx();
        for (int k = 0; k < m_nrx; k++)
            m_buf[bpos(k, m_lsb)] = pat[(m_ncmd + m_ntx + k) % 608];
    endfunction

    always @(posedge clk) begin
        int wa;
        wa = int'(bus_waddr);
        if (rst) begin
            m_opc = '0; m_cnt = '0; m_buf = '0; m_sel = '0;
            m_div = 0; m_lsb = 0; m_busy = 1'b0; m_c = 0; m_total = 0; m_per = 2;
        end else begin
            if (bus_wr_en && wa == 14) m_sel = bus_wdata[1:0];
            if (bus_wr_en && !m_busy) begin
                if (wa == 1) m_opc = bus_wdata;
                if (wa == 11) m_cnt = bus_wdata;
                if (wa == 10) begin m_div = int'(bus_wdata[27:16]); m_lsb = int'(bus_wdata[3]); end
                if (wa >= 2 && wa <= 9) m_buf[32 * (wa - 2) +: 32] = bus_wdata;
            end
            if (m_busy) begin
                if (m_c == m_total * m_per) begin
                    m_busy = 1'b0;
                    apply_rx();
                end else m_c++;
            end else if (bus_wr_en && wa == 0 && bus_wdata[8]) begin
                build_stream();
                m_busy = 1'b1;
                m_c = 0;
                m_per = m_div + 2;
            end
        end
    end

    // per-clock comparison of SCK, selects and busy flag
    always @(negedge clk) begin
        bit exp_sck;
        #1;
        if (!rst) begin
            exp_sck = m_busy && (m_c < m_total * m_per) && ((m_c % m_per) >= (m_per - m_per / 2));
            chk("R3 sck waveform", {31'b0, spi_sck}, {31'b0, exp_sck});
            chk("R12 select lines", {30'b0, spi_cs_n}, {30'b0, ~m_sel});
            if (!bus_wr_en && bus_waddr == 4'd0)
                chk("R2 busy flag", {31'b0, bus_rdata[16]}, {31'b0, m_busy});
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #3;
        bus_wr_en = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk); #3;
        bus_wr_en = 1'b0; bus_waddr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); #3;
        bus_waddr = a; #1;
        d = bus_rdata;
        bus_waddr = '0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
        repeat (2) @(negedge clk);
    endtask

    task automatic prep_slave();
        for (int i = 0; i < 19; i++) pat[32*i +: 32] = $urandom;
        got_q.delete();
        edges = 0;
    endtask

    task automatic check_stream(input string req);
        int bad;
        bad = 0;
        chk({req, " mosi bit count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            if (got_q[i] != exp_q[i]) bad++;
        chk({req, " mosi bit mismatches"}, bad, 0);
    endtask

    task automatic check_buf(input string req);
        logic [31:0] v;
        for (int w = 0; w < 8; w++) begin
            rd(4'(2 + w), v);
            chk(req, v, m_buf[32*w +: 32]);
        end
    endtask

    task automatic xfer(input string req, input logic [31:0] opc, input logic [31:0] cnt);
        wr(4'd1, opc);
        wr(4'd11, cnt);
        prep_slave();
        wr(4'd0, 32'h0000_0100);
        wait_idle();
        check_stream(req);
        check_buf({req, " buffer after receive"});
    endtask

    task automatic load_buf();
        for (int w = 0; w < 8; w++) wr(4'(2 + w), $urandom);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v);  chk("R1 ctrl reset", v, 32'h0);
        rd(4'd1, v);  chk("R1 opcode reset", v, 32'h0);
        rd(4'd2, v);  chk("R1 buffer reset", v, 32'h0);
        rd(4'd10, v); chk("R1 cfg reset", v, 32'h0);
        rd(4'd11, v); chk("R1 count reset", v, 32'h0);
        rd(4'd14, v); chk("R1 select reset", v, 32'h0);
        chk("R1 cs_n reset", {30'b0, spi_cs_n}, 32'h3);
        chk("R1 sck reset", {31'b0, spi_sck}, 32'h0);

        // R1/R7 configuration readback, mode bits read zero
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd10, v); chk("R1 cfg readback", v, 32'h0FFF_0008);

        // R4 R5 R6 R8: byte command, 3 tx bytes, 4 rx bytes, fastest clock, MSB first
        wr(4'd10, 32'h0000_0000);
        load_buf();
        xfer("R5 R6 R8 msb", 32'h0000_0003, {8'd8, 12'd32, 12'd24});

        // R7 R3: full opcode word, LSB first, odd period 5, partial rx byte
        wr(4'd10, (32'd3 << 16) | 32'h8);
        load_buf();
        xfer("R7 lsb odd period", 32'h1122_3344, {8'd32, 12'd20, 12'd0});

        // R5 partial command byte, full 256-bit transmit
        wr(4'd10, 32'd1 << 16);
        load_buf();
        xfer("R5 R6 partial cmd full tx", 32'h0000_A5C3, {8'd12, 12'd0, 12'd256});

        // R10 all counts zero
        xfer("R10 empty transaction", 32'h0000_00FF, 32'h0);
        chk("R10 no sck edge", got_q.size(), 0);

        // R9 clamping of oversize fields
        wr(4'd10, 32'h0);
        load_buf();
        xfer("R9 clamped counts", 32'hDEAD_BEEF, {8'd40, 12'd4095, 12'd300});
        rd(4'd11, v); chk("R9 count raw readback", v, {8'd40, 12'd4095, 12'd300});

        // R11 R12 R2: activity while busy
        wr(4'd14, 32'h1);
        chk("R12 select 0 low", {30'b0, spi_cs_n}, 32'h2);
        wr(4'd10, 32'd9 << 16);
        load_buf();
        wr(4'd1, 32'h0000_0096);
        wr(4'd11, {8'd8, 12'd8, 12'd0});
        prep_slave();
        wr(4'd0, 32'h0000_0100);
        rd(4'd0, v);  chk("R2 busy bit set", v, 32'h0001_0000);
        wr(4'd7, 32'h1234_5678);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd10, 32'h0);
        wr(4'd11, 32'h0);
        wr(4'd0, 32'h0000_0100);
        rd(4'd8, v);  chk("R11 buffer read while busy", v, m_buf[32*6 +: 32]);
        wr(4'd14, 32'h2);
        chk("R12 select written while busy", {30'b0, spi_cs_n}, 32'h1);
        wait_idle();
        check_stream("R11 stream unaffected");
        check_buf("R11 buffer after busy writes");
        rd(4'd1, v);  chk("R11 opcode kept", v, 32'h0000_0096);
        rd(4'd10, v); chk("R11 cfg kept", v, 32'd9 << 16);
        rd(4'd11, v); chk("R11 count kept", v, {8'd8, 12'd8, 12'd0});
        rd(4'd0, v);  chk("R2 busy clear", v, 32'h0);

        // R3 largest divider, R12 select persists
        wr(4'd10, 32'd4095 << 16);
        xfer("R3 max divider", 32'h0000_0080, {8'd1, 12'd0, 12'd0});
        chk("R12 select held", {30'b0, spi_cs_n}, 32'h1);
        wr(4'd14, 32'h0);
        chk("R12 select released", {30'b0, spi_cs_n}, 32'h3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule